// File: doc/BRIEF.md
# Pixel Run Fill and Copy Engine

This engine speeds up short horizontal runs of pixel updates in a framebuffer whose main plane holds one 8-bit palette index per pixel. Two optional planes hold a 32-bit word per pixel: a true-colour plane and a control plane. Software starts an operation with two 32-bit writes. A write whose word-address bit 0 is clear only stores a colour. A write whose word-address bit 0 is set starts an operation. The pixel address of that write is the destination. Its data word carries a source pixel address and a run length.

A source field of all ones selects fill: every pixel in the run takes the stored colour. Any other source value selects copy: the run is copied from the source address, in ascending order. While an operation runs, the engine drives a pixel memory port with one write per cycle. When it ends, it reports the destination range as dirty so that scan-out can refresh it. Commands that arrive while it is busy are held off by a valid/ready handshake.

Top module: `pixrun_engine`

## Requirements
- R1: After reset, `busy` is 0, `bus_ready` is 1, and no pixel write or dirty report is issued.
- R2: An accepted write with `bus_addr[0]` = 0 stores `bus_wdata[23:0]` as the colour and starts no operation.
- R3: An accepted write with `bus_addr[0]` = 1 starts an operation whose destination pixel is `bus_addr[20:1]`. The source pixel is `bus_wdata[19:0]`. Data bits 31:29 have no effect.
- R4: The run length is `bus_wdata[28:24]` + 1, which gives 1 to 32 pixels. Pixel writes go to dest, dest+1, and so on, one per cycle.
- R5: When `bus_wdata[23:0]` is 0xFFFFFF the operation is a fill. Each destination index becomes the colour's low byte.
- R6: Any other source value is a copy. The result equals copying pixel by pixel in ascending order, so a later pixel sees values written earlier in the same run. With dest = src+1, the whole run takes the value of source pixel 0.
- R7: With `tc_mode` = 1 at the start, a fill writes the word {c[7:0], c[15:8], c[23:16], 8'h00} into the true-colour plane, and a copy copies true-colour words. With `tc_mode` = 0 that plane is left untouched.
- R8: The control plane gets the same fill word or copied words only when both `tc_mode` and `ctrl_mode` are 1. Otherwise it is left untouched.
- R9: `bus_rdata` is always 0.
- R10: One cycle after the last pixel write, `dirty_valid` pulses for one cycle, with `dirty_base` = dest and `dirty_len` = run length.
- R11: `busy` is high for length+1 cycles, starting in the cycle after acceptance. `bus_ready` is low exactly while `busy` is high, so any write during that time waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_mode | input | 1 | Enable true-colour plane updates |
| ctrl_mode | input | 1 | Enable control plane updates (needs tc_mode) |
| bus_valid | input | 1 | Write request |
| bus_ready | output | 1 | Write accepted when high with bus_valid |
| bus_addr | input | 21 | Word address; bit 0 selects colour/command, bits 20:1 destination |
| bus_wdata | input | 32 | Colour or command word |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| pm_rd_en | output | 1 | Pixel read strobe (data returns next cycle) |
| pm_rd_addr | output | 20 | Pixel read address |
| pm_rd_idx | input | 8 | Index plane read data |
| pm_rd_tc | input | 32 | True-colour plane read data |
| pm_rd_cp | input | 32 | Control plane read data |
| pm_wr_en | output | 1 | Index plane write strobe |
| pm_wr_tc_en | output | 1 | True-colour plane write strobe |
| pm_wr_cp_en | output | 1 | Control plane write strobe |
| pm_wr_addr | output | 20 | Pixel write address |
| pm_wr_idx | output | 8 | Index write data |
| pm_wr_tc | output | 32 | True-colour write data |
| pm_wr_cp | output | 32 | Control write data |
| dirty_valid | output | 1 | Dirty range report strobe |
| dirty_base | output | 20 | First dirty pixel |
| dirty_len | output | 6 | Number of dirty pixels |

## Verification
The hardest case is an overlapping copy whose destination is one pixel above its source. There, each read coincides with the write of the previous pixel, and the memory returns the old value. The stimulus copies runs with dest = src+1, dest = src+2 and dest below src over a preloaded region. It checks every plane against a sequential ascending copy model. A colour write issued during a running fill shows both the hold-off length and that the fill keeps the old colour.

// File: rtl/pixrun_pkg.sv
package pixrun_pkg;
    parameter int PIX_AW  = 20;
    parameter int MAX_RUN = 32;
    parameter int IDX_W   = 8;
    parameter int WORD_W  = 32;
    parameter int LEN_W   = $clog2(MAX_RUN);
    parameter int SRC_W   = 24;

    typedef struct packed {
        logic [PIX_AW-1:0] dst;
        logic [PIX_AW-1:0] src;
        logic [LEN_W-1:0]  len_m1;
        logic              fill;
        logic              fwd;
    } op_t;

    typedef struct packed {
        op_t               op;
        logic              run;
        logic              tc;
        logic              cp;
        logic              wr_pend;
        logic              dirty;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  wr_off;
        logic [23:0]       colour;
        logic [IDX_W-1:0]  last_idx;
        logic [WORD_W-1:0] last_tc;
        logic [WORD_W-1:0] last_cp;
    } seq_t;
endpackage

// File: rtl/pixrun_decode.sv
module pixrun_decode
    import pixrun_pkg::*;
(
    input  logic [PIX_AW-1:0] dst_in,
    input  logic [28:0]       cmd,
    output op_t               op
);
    always_comb begin
        op.dst    = dst_in;
        op.src    = cmd[PIX_AW-1:0];
        op.len_m1 = cmd[SRC_W+LEN_W-1:SRC_W];
        op.fill   = &cmd[SRC_W-1:0];
        op.fwd    = (dst_in - cmd[PIX_AW-1:0]) == PIX_AW'(1);
    end
endmodule

// File: rtl/pixrun_pack.sv
module pixrun_pack
    import pixrun_pkg::*;
(
    input  logic [23:0]       colour,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [WORD_W-1:0] fill_word
);
    always_comb begin
        fill_idx  = colour[IDX_W-1:0];
        fill_word = {colour[7:0], colour[15:8], colour[23:16], 8'h00};
    end
endmodule

// File: rtl/pixrun_wrsel.sv
module pixrun_wrsel
    import pixrun_pkg::*;
(
    input  logic              fill,
    input  logic              fwd_hit,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [WORD_W-1:0] fill_word,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_tc,
    input  logic [WORD_W-1:0] rd_cp,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [WORD_W-1:0] last_tc,
    input  logic [WORD_W-1:0] last_cp,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_tc,
    output logic [WORD_W-1:0] wr_cp
);
    always_comb begin
        if (fill) begin
            wr_idx = fill_idx;
            wr_tc  = fill_word;
            wr_cp  = fill_word;
        end else if (fwd_hit) begin
            wr_idx = last_idx;
            wr_tc  = last_tc;
            wr_cp  = last_cp;
        end else begin
            wr_idx = rd_idx;
            wr_tc  = rd_tc;
            wr_cp  = rd_cp;
        end
    end
endmodule

// File: rtl/pixrun_engine.sv
module pixrun_engine
    import pixrun_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc_mode,
    input  logic              ctrl_mode,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic [PIX_AW:0]   bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              busy,
    output logic              pm_rd_en,
    output logic [PIX_AW-1:0] pm_rd_addr,
    input  logic [IDX_W-1:0]  pm_rd_idx,
    input  logic [WORD_W-1:0] pm_rd_tc,
    input  logic [WORD_W-1:0] pm_rd_cp,
    output logic              pm_wr_en,
    output logic              pm_wr_tc_en,
    output logic              pm_wr_cp_en,
    output logic [PIX_AW-1:0] pm_wr_addr,
    output logic [IDX_W-1:0]  pm_wr_idx,
    output logic [WORD_W-1:0] pm_wr_tc,
    output logic [WORD_W-1:0] pm_wr_cp,
    output logic              dirty_valid,
    output logic [PIX_AW-1:0] dirty_base,
    output logic [LEN_W:0]    dirty_len
);
    seq_t s_q, s_d;
    op_t  dec_op;
    logic [IDX_W-1:0]  fill_idx;
    logic [WORD_W-1:0] fill_word;
    logic col_take, cmd_take;
    logic unused_hi_bits;

    assign unused_hi_bits = ^bus_wdata[WORD_W-1:29];

    pixrun_decode u_decode (
        .dst_in (bus_addr[PIX_AW:1]),
        .cmd    (bus_wdata[28:0]),
        .op     (dec_op)
    );

    pixrun_pack u_pack (
        .colour    (s_q.colour),
        .fill_idx  (fill_idx),
        .fill_word (fill_word)
    );

    pixrun_wrsel u_wrsel (
        .fill      (s_q.op.fill),
        .fwd_hit   (s_q.op.fwd && (s_q.wr_off != '0)),
        .fill_idx  (fill_idx),
        .fill_word (fill_word),
        .rd_idx    (pm_rd_idx),
        .rd_tc     (pm_rd_tc),
        .rd_cp     (pm_rd_cp),
        .last_idx  (s_q.last_idx),
        .last_tc   (s_q.last_tc),
        .last_cp   (s_q.last_cp),
        .wr_idx    (pm_wr_idx),
        .wr_tc     (pm_wr_tc),
        .wr_cp     (pm_wr_cp)
    );

    assign busy      = s_q.run || s_q.wr_pend;
    assign bus_ready = !busy;
    assign bus_rdata = '0;
    assign col_take  = bus_valid && !busy && !bus_addr[0];
    assign cmd_take  = bus_valid && !busy && bus_addr[0];

    assign pm_rd_en    = s_q.run && !s_q.op.fill;
    assign pm_rd_addr  = s_q.op.src + PIX_AW'(s_q.cnt);
    assign pm_wr_en    = s_q.wr_pend;
    assign pm_wr_tc_en = s_q.wr_pend && s_q.tc;
    assign pm_wr_cp_en = s_q.wr_pend && s_q.cp;
    assign pm_wr_addr  = s_q.op.dst + PIX_AW'(s_q.wr_off);

    assign dirty_valid = s_q.dirty;
    assign dirty_base  = s_q.op.dst;
    assign dirty_len   = {1'b0, s_q.op.len_m1} + 1'b1;

    always_comb begin
        s_d       = s_q;
        s_d.dirty = 1'b0;
        if (col_take) begin
            s_d.colour = bus_wdata[23:0];
        end
        if (cmd_take) begin
            s_d.op  = dec_op;
            s_d.run = 1'b1;
            s_d.cnt = '0;
            s_d.tc  = tc_mode;
            s_d.cp  = tc_mode && ctrl_mode;
        end
        s_d.wr_pend = s_q.run;
        s_d.wr_off  = s_q.cnt;
        if (s_q.run) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == s_q.op.len_m1) begin
                s_d.run = 1'b0;
            end
        end
        if (s_q.wr_pend) begin
            s_d.last_idx = pm_wr_idx;
            s_d.last_tc  = pm_wr_tc;
            s_d.last_cp  = pm_wr_cp;
            if (s_q.wr_off == s_q.op.len_m1) begin
                s_d.dirty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_wr_en && $past(pm_wr_en)) |-> ((pm_wr_addr - $past(pm_wr_addr)) == PIX_AW'(1))); // R4
    AST_CMD_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_addr[0]) |=> busy); // R11
    AST_COL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_addr[0]) |=> !busy); // R2
    AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pm_wr_en); // R11
    AST_DIRTY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> ($past(pm_wr_en) && !pm_wr_en)); // R10
    AST_CP_NEEDS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        pm_wr_cp_en |-> (pm_wr_tc_en && pm_wr_en)); // R8
    AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd_en |-> busy); // R6
endmodule

// File: tb/pixrun_engine_bench.sv
module pixrun_engine_bench;
    logic clk = 0;
    logic rst_n = 0;
    logic tc_mode = 0, ctrl_mode = 0;
    logic bus_valid = 0;
    logic bus_ready;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic busy;
    logic pm_rd_en;
    logic [19:0] pm_rd_addr;
    logic [7:0] pm_rd_idx;
    logic [31:0] pm_rd_tc, pm_rd_cp;
    logic pm_wr_en, pm_wr_tc_en, pm_wr_cp_en;
    logic [19:0] pm_wr_addr;
    logic [7:0] pm_wr_idx;
    logic [31:0] pm_wr_tc, pm_wr_cp;
    logic dirty_valid;
    logic [19:0] dirty_base;
    logic [5:0] dirty_len;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [23:0] cur_col = '0;

    byte unsigned m8[int];
    int unsigned mtc[int], mcp[int];
    byte unsigned e8[int];
    int unsigned etc_[int], ecp[int];

    always #10 clk = ~clk;

    pixrun_engine u_pixrun_engine (.*);

    function automatic byte unsigned g8(ref byte unsigned a[int], input int k);
        return a.exists(k) ? a[k] : 8'd0;
    endfunction
    function automatic int unsigned gw(ref int unsigned a[int], input int k);
        return a.exists(k) ? a[k] : 32'd0;
    endfunction

    always @(posedge clk) begin
        if (pm_rd_en) begin
            pm_rd_idx <= g8(m8, int'(pm_rd_addr));
            pm_rd_tc  <= gw(mtc, int'(pm_rd_addr));
            pm_rd_cp  <= gw(mcp, int'(pm_rd_addr));
        end
        if (pm_wr_en)    m8[int'(pm_wr_addr)]  = pm_wr_idx;
        if (pm_wr_tc_en) mtc[int'(pm_wr_addr)] = pm_wr_tc;
        if (pm_wr_cp_en) mcp[int'(pm_wr_addr)] = pm_wr_cp;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_rdata == 32'd0, "R9", "read data", bus_rdata, 0);
            chk(bus_ready == !busy, "R11", "ready vs busy", bus_ready, !busy);
        end
    end

    initial begin
        #(20ns * 100000);
        chk(0, "WATCHDOG", "timeout", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int unsigned swapc(input logic [23:0] c);
        return {c[7:0], c[15:8], c[23:16], 8'h00};
    endfunction

    task automatic model(input int dst, input int src, input int len, input bit fill,
                         input bit tcm, input bit cpm, input logic [23:0] col);
        for (int k = 0; k < len; k++) begin
            int d = (dst + k) & 32'hFFFFF;
            int s = (src + k) & 32'hFFFFF;
            if (fill) begin
                e8[d] = col[7:0];
                if (tcm) etc_[d] = swapc(col);
                if (tcm && cpm) ecp[d] = swapc(col);
            end else begin
                e8[d] = g8(e8, s);
                if (tcm) etc_[d] = gw(etc_, s);
                if (tcm && cpm) ecp[d] = gw(ecp, s);
            end
        end
    endtask

    task automatic compare(input int dst, input int len, input string req);
        int b8 = 0, btc = 0, bcp = 0;
        for (int a = dst - 1; a <= dst + len; a++) begin
            int k = a & 32'hFFFFF;
            if (g8(m8, k) != g8(e8, k)) begin
                b8++;
                $display("  pixel %0h idx %0h exp %0h", k, g8(m8, k), g8(e8, k));
            end
            if (gw(mtc, k) != gw(etc_, k)) btc++;
            if (gw(mcp, k) != gw(ecp, k)) bcp++;
        end
        chk(b8 == 0, req, "index plane mismatches", b8, 0);
        chk(btc == 0, req, "true-colour plane mismatches", btc, 0);
        chk(bcp == 0, req, "control plane mismatches", bcp, 0);
    endtask

    task automatic set_colour(input logic [31:0] c);
        @(negedge clk);
        bus_valid = 1; bus_addr = 21'h000200; bus_wdata = c;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 0;
        cur_col = c[23:0];
    endtask

    task automatic run_op(input int dst, input int src, input int len, input bit tcm,
                          input bit cpm, input logic [2:0] hi, input string req);
        bit fill = (src == 32'hFFFFFF);
        int bad = 0;
        @(negedge clk);
        tc_mode = tcm; ctrl_mode = cpm;
        bus_valid = 1;
        bus_addr = 21'((dst << 1) | 1);
        bus_wdata = {hi, 5'(len - 1), 24'(src)};
        @(posedge clk);
        @(negedge clk);
        bus_valid = 0;
        for (int k = 1; k <= len + 1; k++) begin
            if (!busy || dirty_valid) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R11", "cycles with wrong busy", bad, 0);
        chk(dirty_valid == 1'b1 && busy == 1'b0, "R10", "dirty pulse", dirty_valid, 1);
        chk(dirty_base == 20'(dst), "R10", "dirty base", dirty_base, dst);
        chk(dirty_len == 6'(len), "R4", "dirty length", dirty_len, len);
        @(negedge clk);
        chk(dirty_valid == 1'b0, "R10", "dirty single cycle", dirty_valid, 0);
        model(dst, src, len, fill, tcm, cpm, cur_col);
        compare(dst, len, req);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            m8[i] = 8'((i * 37 + 5) & 255); e8[i] = m8[i];
            mtc[i] = (i * 32'h01010101) ^ 32'hA5000000; etc_[i] = mtc[i];
            mcp[i] = ~i; ecp[i] = mcp[i];
        end
        repeat (3) @(negedge clk);
        chk(busy == 0 && bus_ready == 1, "R1", "idle after reset", busy, 0);
        chk(pm_wr_en == 0 && dirty_valid == 0, "R1", "quiet after reset", pm_wr_en, 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && pm_wr_en == 0, "R1", "idle out of reset", busy, 0);

        set_colour(32'hFFC3B2A1);
        begin
            int act = 0;
            for (int k = 0; k < 4; k++) begin
                if (busy || pm_wr_en || dirty_valid) act++;
                @(negedge clk);
            end
            chk(act == 0, "R2", "colour write started activity", act, 0);
        end

        run_op(32'h100, 32'hFFFFFF, 5, 0, 0, 3'b000, "R5");
        run_op(32'h040, 32'hFFFFFF, 32, 1, 0, 3'b000, "R7");
        run_op(32'h080, 32'hFFFFFF, 3, 1, 1, 3'b000, "R8");
        run_op(32'h120, 32'h010, 8, 1, 0, 3'b000, "R6");
        run_op(32'h130, 32'h007, 1, 0, 0, 3'b000, "R4");
        run_op(32'h021, 32'h020, 6, 1, 1, 3'b000, "R6");
        run_op(32'h032, 32'h030, 7, 1, 0, 3'b000, "R6");
        run_op(32'h050, 32'h055, 10, 0, 0, 3'b000, "R6");
        run_op(32'h140, 32'h060, 4, 1, 1, 3'b000, "R8");
        run_op(32'h150, 32'h070, 4, 0, 1, 3'b000, "R8");
        run_op(32'h160, 32'h0A0, 5, 1, 0, 3'b111, "R3");
        run_op(32'hFFF00, 32'h0C0, 9, 1, 1, 3'b010, "R3");

        begin
            int waits = 0;
            int old_col;
            old_col = cur_col;
            @(negedge clk);
            tc_mode = 1; ctrl_mode = 0;
            bus_valid = 1; bus_addr = 21'((32'h170 << 1) | 1);
            bus_wdata = {3'b000, 5'd3, 24'hFFFFFF};
            @(posedge clk);
            @(negedge clk);
            bus_addr = 21'(32'h170 << 1); bus_wdata = 32'h00112233;
            while (!bus_ready && waits < 100) begin
                waits++;
                @(negedge clk);
            end
            chk(waits == 5, "R11", "hold-off cycles", waits, 5);
            chk(dirty_valid == 1'b1, "R10", "dirty at release", dirty_valid, 1);
            @(posedge clk);
            @(negedge clk);
            bus_valid = 0;
            model(32'h170, 32'hFFFFFF, 4, 1, 1, 0, 24'(old_col));
            compare(32'h170, 4, "R11");
            cur_col = 24'h112233;
            run_op(32'h180, 32'hFFFFFF, 2, 1, 0, 3'b000, "R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule